// File: doc/BRIEF.md
# HDLC Receive Zero Deletion and Flag/Abort Detector

This block is the bit-level front end of a bit-oriented synchronous receiver. It takes one received bit per `bit_en` strobe and tracks how many ones have arrived in a row. From that count it makes one of three decisions after a run of five ones. A 0 that follows exactly five ones is a stuffed bit and is removed. A 0 that follows six ones closes a flag. A seventh one marks an abort.

Every bit is held in a short line of `RUN_LEN + 2` slots until its fate is known. A flag or an abort invalidates the slots that belong to it, so only payload bits leave the block. Those bits come out on `data_out` with a one-clock `data_valid` strobe. Separate one-clock pulses report each flag and each abort. A downstream deserializer uses `flag_seen` to restart its byte alignment.

Top module: `hdlc_zero_delete_rx`

## Requirements
- R1: While `rst_n` is low, `data_out`, `data_valid`, `flag_seen` and `abort_seen` are 0. Reset discards every held bit, so none of them is forwarded after reset.
- R2: Each surviving bit is forwarded in arrival order. It appears on `data_out` with `data_valid` high for one clock, directly after the `bit_en` strobe that delivers the seventh bit after it (`RUN_LEN + 2` strobes later).
- R3: A 0 received directly after exactly five consecutive 1s is dropped, and no gap is left in the forwarded stream.
- R4: The sequence 0,1,1,1,1,1,1,0 (a 0, six 1s, then a 0) is a flag. `flag_seen` is high for one clock after the strobe of its closing 0, and none of its eight bits is forwarded.
- R5: A seventh consecutive 1 raises `abort_seen` for one clock. The 0 before the run and every 1 of the run are not forwarded. Further 1s raise no further pulse.
- R6: The 0 that ends an abort run is forwarded as data. After it, a new run of seven 1s raises `abort_seen` again.
- R7: Any 0 clears the run count. A run of fewer than five 1s, and the 0 after it, pass through unchanged.
- R8: `bit_in` is ignored while `bit_en` is low. `data_valid`, `flag_seen` and `abort_seen` are high only in the clock that follows a strobe.
- R9: Two flags that share one 0 (0, six 1s, 0, six 1s, 0) are both reported. Neither forwards a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Marks a cycle that carries a received bit |
| bit_in | input | 1 | Received serial bit |
| data_out | output | 1 | Forwarded (de-stuffed) bit |
| data_valid | output | 1 | One-clock strobe qualifying `data_out` |
| flag_seen | output | 1 | One-clock pulse: a flag was completed |
| abort_seen | output | 1 | One-clock pulse: an abort was recognised |

## Verification
The bit patterns are chosen so that each one isolates a single branch of the decision taken after five 1s.

- Plain mixed data and runs of four 1s show that nothing is removed when the count never reaches five.
- Runs of five 1s followed by a 0 must lose exactly that 0.
- An embedded flag, and two flags that share a 0, must vanish from the output while producing pulses.
- A long run of 1s tells a single abort apart from repeated ones. A second abort after an intervening 0 shows that detection re-arms.

Directed sequences then check the exact strobe latency, the flag pulse timing, a reset in the middle of the stream, and idle cycles with a toggling `bit_in`.

// File: rtl/hdlc_zd_pkg.sv
package hdlc_zd_pkg;

   // Decision taken for one received bit
   typedef enum logic [2:0] {
      ACT_DATA   = 3'd0,  // keep the bit (tentatively, it may still be flushed)
      ACT_DELETE = 3'd1,  // stuffed zero: drop it
      ACT_FLAG   = 3'd2,  // closing 0 of a flag: drop and flush held bits
      ACT_ABORT  = 3'd3,  // seventh 1: drop and flush held bits, pulse
      ACT_DROP   = 3'd4   // further 1 inside an abort run: drop silently
   } zd_act_e;

endpackage

// File: rtl/hdlc_zd_run_cnt.sv
module hdlc_zd_run_cnt #(
   parameter int RUN_LEN = 5,
   parameter int SAT     = RUN_LEN + 2,
   parameter int CW      = $clog2(SAT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic          bit_in,
   output logic [CW-1:0] ones_cnt
);

   localparam logic [CW-1:0] SAT_V = CW'(SAT);

   generate
      if (SAT < 3) begin : g_bad_sat
         $error("hdlc_zd_run_cnt: SAT must be at least 3");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bit_en) begin
         if (!bit_in)
            cnt_q <= '0;
         else if (cnt_q != SAT_V)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ones_cnt = cnt_q;

   // R7: a received 0 always clears the run count
   a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !bit_in) |=> (ones_cnt == '0));

   // R5: the count saturates and never passes its ceiling
   a_r5_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      ones_cnt <= SAT_V);

   // R8: without a strobe the count holds
   a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(ones_cnt));

endmodule

// File: rtl/hdlc_zd_classify.sv
module hdlc_zd_classify
   import hdlc_zd_pkg::*;
#(
   parameter int RUN_LEN = 5,
   parameter int CW      = $clog2(RUN_LEN + 3)
) (
   input  logic [CW-1:0] ones_cnt,
   input  logic          bit_in,
   output zd_act_e       act
);

   localparam logic [CW-1:0] STUFF_AT = CW'(RUN_LEN);
   localparam logic [CW-1:0] FLAG_AT  = CW'(RUN_LEN + 1);

   always_comb begin
      if (!bit_in) begin
         if (ones_cnt == STUFF_AT)
            act = ACT_DELETE;
         else if (ones_cnt == FLAG_AT)
            act = ACT_FLAG;
         else
            act = ACT_DATA;
      end else begin
         if (ones_cnt == FLAG_AT)
            act = ACT_ABORT;
         else if (ones_cnt > FLAG_AT)
            act = ACT_DROP;
         else
            act = ACT_DATA;
      end
   end

endmodule

// File: rtl/hdlc_zd_hold_line.sv
module hdlc_zd_hold_line #(
   parameter int DEPTH = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic flush,
   input  logic in_bit,
   input  logic in_valid,
   output logic tail_bit,
   output logic tail_valid
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("hdlc_zd_hold_line: DEPTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] bit_q;
   logic [DEPTH-1:0] vld_q;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q <= '0;
               vld_q <= '0;
            end else if (shift_en) begin
               bit_q <= in_bit;
               vld_q <= in_valid & ~flush;
            end
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q <= '0;
               vld_q <= '0;
            end else if (shift_en) begin
               bit_q <= {bit_q[DEPTH-2:0], in_bit};
               if (flush)
                  vld_q <= '0;
               else
                  vld_q <= {vld_q[DEPTH-2:0], in_valid};
            end
         end
      end
   endgenerate

   assign tail_bit   = bit_q[DEPTH-1];
   assign tail_valid = vld_q[DEPTH-1];

   // R4/R5: after a flush no held slot is still marked valid
   a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && flush) |=> (vld_q == '0));

endmodule

// File: rtl/hdlc_zero_delete_rx.sv
module hdlc_zero_delete_rx
   import hdlc_zd_pkg::*;
#(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic bit_in,
   output logic data_out,
   output logic data_valid,
   output logic flag_seen,
   output logic abort_seen
);

   localparam int SAT  = RUN_LEN + 2;
   localparam int CW   = $clog2(SAT + 1);
   localparam int HOLD = RUN_LEN + 2;

   generate
      if (RUN_LEN < 1) begin : g_bad_run
         $error("hdlc_zero_delete_rx: RUN_LEN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] ones_cnt;
   zd_act_e       act;
   logic          kill;
   logic          keep;
   logic          tail_bit;
   logic          tail_valid;

   hdlc_zd_run_cnt #(.RUN_LEN(RUN_LEN), .SAT(SAT), .CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .bit_in   (bit_in),
      .ones_cnt (ones_cnt)
   );

   hdlc_zd_classify #(.RUN_LEN(RUN_LEN), .CW(CW)) u_cls (
      .ones_cnt (ones_cnt),
      .bit_in   (bit_in),
      .act      (act)
   );

   assign kill = (act == ACT_FLAG) || (act == ACT_ABORT);
   assign keep = (act == ACT_DATA);

   hdlc_zd_hold_line #(.DEPTH(HOLD)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (bit_en),
      .flush      (kill),
      .in_bit     (bit_in),
      .in_valid   (keep),
      .tail_bit   (tail_bit),
      .tail_valid (tail_valid)
   );

   logic dout_q, dval_q, flag_q, abort_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q  <= 1'b0;
         dval_q  <= 1'b0;
         flag_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         dval_q  <= bit_en & tail_valid & ~kill;
         flag_q  <= bit_en & (act == ACT_FLAG);
         abort_q <= bit_en & (act == ACT_ABORT);
         if (bit_en)
            dout_q <= tail_bit;
      end
   end

   assign data_out   = dout_q;
   assign data_valid = dval_q;
   assign flag_seen  = flag_q;
   assign abort_seen = abort_q;

   // Checker state for R6: a 0 has arrived since the last abort pulse
   logic zero_since_abort;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         zero_since_abort <= 1'b1;
      else if (bit_en && !bit_in)
         zero_since_abort <= 1'b1;
      else if (abort_q)
         zero_since_abort <= 1'b0;
   end

   // R8: outputs pulse only in the clock after a strobe
   a_r8_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid || flag_seen || abort_seen) |-> $past(bit_en));

   // R4: a flag bit is never forwarded in the same clock as the flag pulse
   a_r4_flag_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      flag_seen |-> !data_valid);

   // R5: an abort pulse lasts one clock and carries no data
   a_r5_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      abort_seen |=> !abort_seen);
   a_r5_abort_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      abort_seen |-> !data_valid);

   // R6: successive abort pulses need a 0 between them
   a_r6_rearm_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
      abort_seen |-> zero_since_abort);

   // R9: flag and abort pulses are exclusive
   a_r9_flag_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_seen && abort_seen));

endmodule

// File: tb/hdlc_zero_delete_rx_tb.sv
module hdlc_zero_delete_rx_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic bit_in = 1'b0;
   logic data_out, data_valid, flag_seen, abort_seen;

   always #5 clk = ~clk;  // 100 MHz

   hdlc_zero_delete_rx #(.RUN_LEN(5)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .bit_in     (bit_in),
      .data_out   (data_out),
      .data_valid (data_valid),
      .flag_seen  (flag_seen),
      .abort_seen (abort_seen)
   );

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // Stimulus bits sent first-to-last from bit inl-1 down to 0.
   // Expected forwarded bits are right-aligned, oldest at the top.
   // Every run is followed by a trailing flag (adds one flag pulse).
   typedef struct packed {
      logic [31:0] inb;
      logic [5:0]  inl;
      logic [31:0] exb;
      logic [5:0]  exl;
      logic [1:0]  nfl;
      logic [1:0]  nab;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VT [NV] = '{
      '{32'b10100011,          6'd8,  32'b10100011,     6'd8,  2'd0, 2'd0},
      '{32'b01111101,          6'd8,  32'b0111111,      6'd7,  2'd0, 2'd0},
      '{32'b11110111100,       6'd11, 32'b11110111100,  6'd11, 2'd0, 2'd0},
      '{32'b100111111011,      6'd12, 32'b1011,         6'd4,  2'd1, 2'd0},
      '{32'b0111111011111101,  6'd16, 32'b1,            6'd1,  2'd2, 2'd0},
      '{32'b1011111111101,     6'd13, 32'b101,          6'd3,  2'd0, 2'd1},
      '{32'b01111111011111110, 6'd17, 32'b0,            6'd1,  2'd0, 2'd2},
      '{32'b01111111111110,    6'd14, 32'b0,            6'd1,  2'd0, 2'd1},
      '{32'b11111011111010,    6'd14, 32'b111111111110, 6'd12, 2'd0, 2'd0}
   };

   function automatic string vtag(int i);
      case (i)
         0: return "R2";
         1: return "R3";
         2: return "R7";
         3: return "R4";
         4: return "R9";
         5: return "R5";
         6: return "R6";
         7: return "R5";
         default: return "R3";
      endcase
   endfunction

   logic        s_dv, s_do, s_fl, s_ab;
   logic [31:0] cap;
   int          caplen, nflag, nabort, idle_bad;

   task automatic check(input string tag, input string what,
                        input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // One strobe, then one idle cycle with a random bit (R8)
   task automatic send(input logic b);
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = b;
      @(negedge clk);
      s_dv = data_valid; s_do = data_out; s_fl = flag_seen; s_ab = abort_seen;
      if (s_dv) begin
         cap = {cap[30:0], s_do};
         caplen++;
      end
      if (s_fl) nflag++;
      if (s_ab) nabort++;
      bit_en = 1'b0;
      bit_in = 1'($urandom);
      @(negedge clk);
      if (data_valid || flag_seen || abort_seen) idle_bad++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bit_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cap = '0; caplen = 0; nflag = 0; nabort = 0; idle_bad = 0;
   endtask

   task automatic send_flag();
      send(1'b0);
      for (int k = 0; k < 6; k++) send(1'b1);
      send(1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R2 watchdog expired: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R1: outputs held low during reset
      repeat (2) @(negedge clk);
      check("R1", "outputs in reset",
            {data_out, data_valid, flag_seen, abort_seen}, 4'b0000);
      do_reset();

      // Table walk
      for (int v = 0; v < NV; v++) begin
         do_reset();
         for (int i = 0; i < int'(VT[v].inl); i++)
            send(VT[v].inb[int'(VT[v].inl) - 1 - i]);
         send_flag();
         check(vtag(v), $sformatf("vector %0d forwarded count", v),
               caplen, int'(VT[v].exl));
         check(vtag(v), $sformatf("vector %0d forwarded bits", v),
               cap, VT[v].exb);
         check(vtag(v), $sformatf("vector %0d flag pulses", v),
               nflag, int'(VT[v].nfl) + 1);
         check(vtag(v), $sformatf("vector %0d abort pulses", v),
               nabort, int'(VT[v].nab));
         check("R8", $sformatf("vector %0d idle-cycle pulses", v),
               idle_bad, 0);
      end

      // R2: exact latency of seven strobes
      do_reset();
      begin
         int early = 0;
         send(1'b1);
         for (int k = 1; k < 7; k++) begin
            send(1'b0);
            if (s_dv) early++;
         end
         check("R2", "valid before 7th following strobe", early, 0);
         send(1'b0);
         check("R2", "valid/data at 7th following strobe", {s_dv, s_do}, 2'b11);
      end

      // R4: flag pulse timing
      do_reset();
      begin
         int pre = 0;
         send(1'b0);
         for (int k = 0; k < 6; k++) begin
            send(1'b1);
            if (s_fl) pre++;
         end
         check("R4", "flag pulse before closing 0", pre, 0);
         send(1'b0);
         check("R4", "flag pulse after closing 0", s_fl, 1);
      end

      // R8: long idle with toggling bit_in produces nothing
      do_reset();
      begin
         int seen = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            bit_in = 1'($urandom);
            if (data_valid || flag_seen || abort_seen) seen++;
         end
         check("R8", "pulses with bit_en low", seen, 0);
      end

      // R1: reset in mid-stream discards held bits
      do_reset();
      send(1'b1); send(1'b1); send(1'b1);
      do_reset();
      begin
         int leak = 0;
         for (int k = 0; k < 7; k++) begin
            send(1'b0);
            if (s_dv) leak++;
         end
         check("R1", "held bits forwarded after reset", leak, 0);
         send(1'b0);
         check("R1", "first post-reset bit forwarded", {s_dv, s_do}, 2'b10);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule